// File: doc/BRIEF.md
# Indirect-Access Asynchronous Host Bus Interface

This block lets an asynchronous microprocessor bus reach an internal register file without ever putting a register address on dedicated address pins. The host first performs a command cycle, with the command pin high, which deposits an address (and, on a 16-bit bus, four byte enables) into a command latch. It then performs data cycles, with the command pin low, which read or write the register selected by that latch. A read with the command pin high returns the latched command word so software can verify it.

Chip select, the read strobe, the write strobe and the command pin come straight from the host with no clock. The two qualified strobes (chip select AND strobe) pass through synchronisers, and an edge detector turns each one into a single internal pulse. The bus width (8 or 16 bits) is taken from a strap on the first clock after reset is released. The byte order is taken from a second strap or, when that strap is low, from one bit of a local mode register that lives inside this block. The bidirectional data bus is modelled as separate input, output and output-enable signals.

Top module: `hostbus_indirect`

## Requirements
- R1: After reset, bus_oe is low, rf_we and rf_re stay low, and a command readback returns 16'h0000.
- R2: In 16-bit mode a command write stores byte enables from bus_din[15:12] and address bits [7:2] from bus_din[7:2]. A command readback returns {enables, 4'b0, addr[7:2], 2'b00}, and every other bit is zero.
- R3: In 8-bit mode a command write stores bus_din[7:0] as the full byte address. A command readback returns {8'h00, address}.
- R4: In 16-bit mode each data write gives exactly one rf_we pulse. The word address is {addr[7:2], h}, where h is 1 when either of the enables [3:2] is set. rf_wbe is enables[3:2] when h is 1 and enables[1:0] otherwise, with bit 0 being the low register byte. When the selected enables are both zero, no write is made.
- R5: In 16-bit Big-Endian mode the two bus bytes are swapped between the bus and the register on both writes and reads. The byte enables always name register bytes.
- R6: The byte order is Big-Endian when the endian strap is high. Otherwise it is the value of bit 11 of a local mode register at byte address 8'hF8 (word 7'h7C), where 1 means Big. Accesses to that address are served locally and never pulse rf_we or rf_re.
- R7: In 8-bit mode a data write puts the byte on both lanes of rf_wdata and sets rf_wbe to 2'b10 when address bit 0 is 1, or 2'b01 when it is 0, at word address addr[7:1]. A data read returns the addressed byte in bus_dout[7:0], with the upper byte zero.
- R8: The width strap is sampled on the first clock after reset release, where low means 8-bit. Later changes to it have no effect until the next reset.
- R9: Strobes given while chip select is high are ignored. The command word and the register file stay unchanged, and bus_oe stays low.
- R10: bus_oe is high exactly while chip select and the read strobe are both low.
- R11: Back-to-back data cycles after one command cycle all access the same register. Each strobe gives exactly one access, and a write and a read never pulse together.
- R12: In 16-bit Little-Endian mode a data read returns rf_rdata of the selected word unchanged. It stays on bus_dout until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_wide | input | 1 | Width strap: 1 = 16-bit, 0 = 8-bit |
| strap_big | input | 1 | Endian strap: 1 forces Big-Endian |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| cmd | input | 1 | 1 = command cycle, 0 = data cycle |
| bus_din | input | 16 | Data bus as seen by the block |
| bus_dout | output | 16 | Data bus value driven by the block |
| bus_oe | output | 1 | Data bus output enable |
| rf_addr | output | 7 | Register file word address |
| rf_we | output | 1 | Register file write pulse |
| rf_wbe | output | 2 | Register byte enables for the write |
| rf_wdata | output | 16 | Register write data |
| rf_re | output | 1 | Register file read pulse |
| rf_rdata | input | 16 | Register file read data for rf_addr |

## Verification
The hardest case to reach is the one where the byte order changes while the block is running. For that, the local mode register has to be written through the same indirect path it then reconfigures. After that write, later writes and reads must show swapped bytes, and a readback of the mode register itself must come back swapped. The bench reaches this by first sending a command cycle that points at the mode register's address. It then writes bit 11 through a data cycle and checks that no register file access was issued. Finally it sends ordinary traffic and a readback of the mode register, and compares the swapped values. Separate resets with the straps set in each direction cover the strap-driven paths.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef struct packed {
    logic [3:0] be;
    logic [7:0] addr;
  } cmd_word_t;

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/hbi_edge_sync.sv
module hbi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign pulse = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/hbi_cmd_reg.sv
module hbi_cmd_reg
  import hbi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        wide,
  input  logic [15:0] din,
  output cmd_word_t   word,
  output logic [15:0] readback
);
  cmd_word_t word_d;

  always_comb begin
    if (wide) begin
      word_d.be   = din[15:12];
      word_d.addr = {din[7:2], 2'b00};
    end else begin
      word_d.be   = 4'h0;
      word_d.addr = din[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word <= '0;
    else if (load) word <= word_d;
  end

  assign readback = wide ? {word.be, 4'h0, word.addr[7:2], 2'b00}
                         : {8'h00, word.addr};
endmodule

// File: rtl/hbi_datapath.sv
module hbi_datapath
  import hbi_pkg::*;
#(
  parameter logic [7:0] MODE_ADDR = 8'hF8
) (
  input  logic        wide,
  input  logic        big,
  input  cmd_word_t   word,
  input  logic [15:0] wdat,
  input  logic [15:0] reg_rdata,
  output logic [6:0]  waddr,
  output logic [1:0]  wbe,
  output logic [15:0] wdata,
  output logic [15:0] bus_rdata,
  output logic        local_hit
);
  logic hi_half;

  always_comb begin
    hi_half = |word.be[3:2];
    if (wide) begin
      waddr = {word.addr[7:2], hi_half};
      wbe   = hi_half ? word.be[3:2] : word.be[1:0];
      wdata = big ? swap16(wdat) : wdat;
      bus_rdata = big ? swap16(reg_rdata) : reg_rdata;
    end else begin
      waddr = word.addr[7:1];
      wbe   = word.addr[0] ? 2'b10 : 2'b01;
      wdata = {wdat[7:0], wdat[7:0]};
      bus_rdata = {8'h00, word.addr[0] ? reg_rdata[15:8] : reg_rdata[7:0]};
    end
    local_hit = (waddr == MODE_ADDR[7:1]);
  end
endmodule

// File: rtl/hostbus_indirect.sv
module hostbus_indirect
  import hbi_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] MODE_ADDR   = 8'hF8,
  parameter int         ENDIAN_BIT  = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_wide,
  input  logic        strap_big,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        cmd,
  input  logic [15:0] bus_din,
  output logic [15:0] bus_dout,
  output logic        bus_oe,
  output logic [6:0]  rf_addr,
  output logic        rf_we,
  output logic [1:0]  rf_wbe,
  output logic [15:0] rf_wdata,
  output logic        rf_re,
  input  logic [15:0] rf_rdata
);
  localparam int NSTB = 2;
  localparam int IDX_WR = 0;
  localparam int IDX_RD = 1;

  logic [NSTB-1:0] stb_lvl;
  logic [NSTB-1:0] stb_pulse;

  assign stb_lvl[IDX_WR] = ~cs_n & ~wr_n;
  assign stb_lvl[IDX_RD] = ~cs_n & ~rd_n;

  for (genvar g = 0; g < NSTB; g++) begin : g_sync
    hbi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .lvl(stb_lvl[g]), .pulse(stb_pulse[g])
    );
  end

  // strap capture on first clock after reset release
  logic init_done, wide_q, sbig_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_done <= 1'b0;
      wide_q    <= 1'b1;
      sbig_q    <= 1'b0;
    end else if (!init_done) begin
      init_done <= 1'b1;
      wide_q    <= strap_wide;
      sbig_q    <= strap_big;
    end
  end

  // capture stage: strobe edge latches command pin and write data
  logic        wr_go, rd_go, go_cmd;
  logic [15:0] wdat_q;
  logic        cap_en;
  assign cap_en = stb_pulse[IDX_WR] | stb_pulse[IDX_RD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_go <= 1'b0;
      rd_go <= 1'b0;
    end else begin
      wr_go <= stb_pulse[IDX_WR];
      rd_go <= stb_pulse[IDX_RD];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      go_cmd <= 1'b0;
    else if (cap_en) go_cmd <= cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wdat_q <= '0;
    else if (stb_pulse[IDX_WR]) wdat_q <= bus_din;
  end

  // command latch
  cmd_word_t   cmd_word;
  logic [15:0] cmd_rb;
  logic        cmd_load;
  assign cmd_load = wr_go & go_cmd;

  hbi_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .load(cmd_load), .wide(wide_q),
    .din(wdat_q), .word(cmd_word), .readback(cmd_rb)
  );

  // local mode register, only the endian bit is held
  logic mode_big_q, mode_big_d, mode_en;
  logic big;
  logic [6:0]  dp_addr;
  logic [1:0]  dp_wbe;
  logic [15:0] dp_wdata, dp_rdata, reg_rdata;
  logic        local_hit;

  assign big = sbig_q | mode_big_q;
  assign reg_rdata = local_hit ? (16'(mode_big_q) << ENDIAN_BIT) : rf_rdata;

  hbi_datapath #(.MODE_ADDR(MODE_ADDR)) u_dp (
    .wide(wide_q), .big(big), .word(cmd_word), .wdat(wdat_q),
    .reg_rdata(reg_rdata), .waddr(dp_addr), .wbe(dp_wbe),
    .wdata(dp_wdata), .bus_rdata(dp_rdata), .local_hit(local_hit)
  );

  always_comb begin
    mode_en    = wr_go & ~go_cmd & local_hit & dp_wbe[ENDIAN_BIT/8];
    mode_big_d = dp_wdata[ENDIAN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_big_q <= 1'b0;
    else if (mode_en) mode_big_q <= mode_big_d;
  end

  // read holding register
  logic [15:0] hold_q, hold_d;
  always_comb hold_d = go_cmd ? cmd_rb : dp_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (rd_go) hold_q <= hold_d;
  end

  assign rf_addr  = dp_addr;
  assign rf_wbe   = dp_wbe;
  assign rf_wdata = dp_wdata;
  assign rf_we    = wr_go & ~go_cmd & ~local_hit & (|dp_wbe);
  assign rf_re    = rd_go & ~go_cmd & ~local_hit;
  assign bus_dout = hold_q;
  assign bus_oe   = stb_lvl[IDX_RD];
endmodule

// File: rtl/hostbus_indirect_chk.sv
module hostbus_indirect_chk
  import hbi_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      rf_we,
  input logic      rf_re,
  input logic [1:0] rf_wbe,
  input logic      wide_q,
  input logic      init_done,
  input logic      wr_go,
  input cmd_word_t cmd_word
);
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we); // R11
  AST_RE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_re |=> !rf_re); // R11
  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && rf_re)); // R11
  AST_NARROW_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !wide_q) |-> $onehot(rf_wbe)); // R7
  AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> $stable(wide_q)); // R8
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> $stable(cmd_word)); // R9
endmodule

bind hostbus_indirect hostbus_indirect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_re(rf_re), .rf_wbe(rf_wbe),
  .wide_q(wide_q), .init_done(init_done), .wr_go(wr_go), .cmd_word(cmd_word)
);

// File: tb/hostbus_indirect_test.sv
module hostbus_indirect_test;
  logic clk = 1'b0;
  logic rst_n, strap_wide, strap_big, cs_n, rd_n, wr_n, cmd;
  logic [15:0] bus_din, bus_dout, rf_wdata, rf_rdata;
  logic bus_oe, rf_we, rf_re;
  logic [6:0] rf_addr;
  logic [1:0] rf_wbe;

  always #5 clk = ~clk;

  hostbus_indirect uut (
    .clk(clk), .rst_n(rst_n), .strap_wide(strap_wide), .strap_big(strap_big),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cmd(cmd), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .rf_addr(rf_addr), .rf_we(rf_we),
    .rf_wbe(rf_wbe), .rf_wdata(rf_wdata), .rf_re(rf_re), .rf_rdata(rf_rdata)
  );

  // register file model
  logic [15:0] mem [128];
  assign rf_rdata = mem[rf_addr];

  int checks = 0, fails = 0;
  int we_cnt = 0, re_cnt = 0;
  logic [6:0]  last_addr;
  logic [1:0]  last_wbe;
  logic [15:0] last_wdata;

  always @(negedge clk) begin
    if (rf_we) begin
      we_cnt++;
      last_addr = rf_addr; last_wbe = rf_wbe; last_wdata = rf_wdata;
      if (rf_wbe[0]) mem[rf_addr][7:0]  = rf_wdata[7:0];
      if (rf_wbe[1]) mem[rf_addr][15:8] = rf_wdata[15:8];
    end
    if (rf_re) re_cnt++;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected < 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic w, input logic b);
    rst_n = 1'b0; strap_wide = w; strap_big = b;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; cmd = 1'b0; bus_din = '0;
    idle(3); rst_n = 1'b1; idle(3);
  endtask

  task automatic bus_wr(input logic c, input logic [15:0] d, input logic sel);
    @(negedge clk);
    cmd = c; bus_din = d; cs_n = ~sel; wr_n = 1'b0;
    idle(7);
    wr_n = 1'b1; cs_n = 1'b1;
    idle(5);
  endtask

  task automatic bus_rd(input logic c, output logic [15:0] d, output logic oe);
    @(negedge clk);
    cmd = c; cs_n = 1'b0; rd_n = 1'b0;
    idle(8);
    d = bus_dout; oe = bus_oe;
    rd_n = 1'b1; cs_n = 1'b1;
    idle(5);
  endtask

  typedef struct packed {
    logic [3:0]  be;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic [6:0]  exp_addr;
    logic [1:0]  exp_wbe;
    logic [15:0] exp_rd;
    logic [15:0] exp_rb;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{4'b0011, 8'h10, 16'h1234, 7'h08, 2'b11, 16'h1234, 16'h3010},
    '{4'b1100, 8'h20, 16'hABCD, 7'h11, 2'b11, 16'hABCD, 16'hC020},
    '{4'b0001, 8'h30, 16'h5566, 7'h18, 2'b01, 16'h0066, 16'h1030},
    '{4'b1000, 8'h40, 16'h7788, 7'h21, 2'b10, 16'h7700, 16'h8040}
  };

  initial begin
    logic [15:0] rd;
    logic oe;
    int n0;
    for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
    do_reset(1'b1, 1'b0);

    // R1 reset state
    chk("R1 oe idle", bus_oe, 0);
    chk("R1 no we", we_cnt, 0);
    bus_rd(1'b1, rd, oe);
    chk("R1 cmd readback", rd, 16'h0000);
    chk("R1 no re", re_cnt, 0);

    // table: R2 R4 R12 in 16-bit little mode
    for (int i = 0; i < 4; i++) begin
      n0 = we_cnt;
      bus_wr(1'b1, {VECS[i].be, 4'h0, VECS[i].addr}, 1'b1);
      bus_rd(1'b1, rd, oe);
      chk("R2 cmd readback", rd, VECS[i].exp_rb);
      bus_wr(1'b0, VECS[i].wdata, 1'b1);
      chk("R4 one write", we_cnt - n0, 1);
      chk("R4 addr", last_addr, VECS[i].exp_addr);
      chk("R4 wbe", last_wbe, VECS[i].exp_wbe);
      bus_rd(1'b0, rd, oe);
      chk("R12 data read", rd, VECS[i].exp_rd);
      chk("R10 oe during read", oe, 1);
    end

    // R2 junk bits are dropped
    bus_wr(1'b1, 16'h3F13, 1'b1);
    bus_rd(1'b1, rd, oe);
    chk("R2 zero fill", rd, 16'h3010);

    // R4 no enables -> no write
    bus_wr(1'b1, 16'h0044, 1'b1);
    n0 = we_cnt;
    bus_wr(1'b0, 16'hFFFF, 1'b1);
    chk("R4 no enables", we_cnt - n0, 0);

    // R9 strobes without chip select
    bus_wr(1'b1, 16'h3010, 1'b1);
    n0 = we_cnt;
    bus_wr(1'b1, 16'hF0FC, 1'b0);
    bus_wr(1'b0, 16'hDEAD, 1'b0);
    chk("R9 no write", we_cnt - n0, 0);
    @(negedge clk); rd_n = 1'b0; idle(6);
    chk("R9 R10 oe without cs", bus_oe, 0);
    rd_n = 1'b1; idle(5);
    bus_rd(1'b1, rd, oe);
    chk("R9 cmd unchanged", rd, 16'h3010);
    bus_rd(1'b0, rd, oe);
    chk("R9 data unchanged", rd, 16'h1234);

    // R11 burst
    bus_wr(1'b1, 16'h3050, 1'b1);
    n0 = we_cnt;
    bus_wr(1'b0, 16'h1111, 1'b1);
    bus_wr(1'b0, 16'h2222, 1'b1);
    chk("R11 two writes", we_cnt - n0, 2);
    chk("R11 same addr", last_addr, 7'h28);
    n0 = re_cnt;
    bus_rd(1'b0, rd, oe);
    bus_rd(1'b0, rd, oe);
    chk("R11 two reads", re_cnt - n0, 2);
    chk("R11 burst data", rd, 16'h2222);

    // R6 R5 mode register endian
    bus_wr(1'b1, 16'h30F8, 1'b1);
    n0 = we_cnt;
    bus_wr(1'b0, 16'h0800, 1'b1);
    chk("R6 local no rf write", we_cnt - n0, 0);
    n0 = re_cnt;
    bus_rd(1'b0, rd, oe);
    chk("R6 R5 mode readback swapped", rd, 16'h0008);
    chk("R6 local no rf read", re_cnt - n0, 0);
    bus_wr(1'b1, 16'h3060, 1'b1);
    bus_wr(1'b0, 16'h1234, 1'b1);
    chk("R5 write swapped", last_wdata, 16'h3412);
    chk("R5 mem", mem[7'h30], 16'h3412);
    bus_rd(1'b0, rd, oe);
    chk("R5 read swapped back", rd, 16'h1234);
    bus_wr(1'b1, 16'h30F8, 1'b1);
    bus_wr(1'b0, 16'h0000, 1'b1);
    bus_wr(1'b1, 16'h3060, 1'b1);
    bus_rd(1'b0, rd, oe);
    chk("R6 back to little", rd, 16'h3412);

    // R6 strap forces big
    do_reset(1'b1, 1'b1);
    bus_wr(1'b1, 16'h3060, 1'b1);
    bus_wr(1'b0, 16'hAABB, 1'b1);
    chk("R6 strap big", last_wdata, 16'hBBAA);

    // R3 R7 R8 8-bit mode
    do_reset(1'b0, 1'b0);
    strap_wide = 1'b1;
    bus_wr(1'b1, 16'h0065, 1'b1);
    bus_rd(1'b1, rd, oe);
    chk("R3 8bit readback", rd, 16'h0065);
    bus_wr(1'b0, 16'h00C3, 1'b1);
    chk("R7 addr", last_addr, 7'h32);
    chk("R7 wbe", last_wbe, 2'b10);
    chk("R7 wdata", last_wdata, 16'hC3C3);
    bus_rd(1'b0, rd, oe);
    chk("R7 read high byte", rd, 16'h00C3);
    bus_wr(1'b1, 16'h0064, 1'b1);
    bus_rd(1'b0, rd, oe);
    chk("R7 read low byte", rd, 16'h0000);
    bus_wr(1'b1, 16'h1234, 1'b1);
    bus_rd(1'b1, rd, oe);
    chk("R8 width held", rd, 16'h0034);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule